// File: doc/BRIEF.md
# Edge-Selectable Interrupt Controller

This block gathers a set of level-type status inputs (overload flags, general-purpose input pins and similar) and turns chosen transitions on them into one active-high interrupt line. Each input has two enables of its own: one arms detection of a low-to-high transition, the other a high-to-low transition. With both set, a flag interrupts both when it becomes true and when it becomes false.

Inputs are asynchronous to the block clock, so each one passes through a synchroniser before its edges are detected. A detected, enabled edge sets a sticky pending bit for that source. The bit stays set until software writes a 1 to that source's clear bit. The interrupt output is high whenever any pending bit is set. The enable masks and the clear mask are written through plain write-strobe ports, and the pending bits can be read back in parallel.

Top module: `irq_edge_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `irq` is 0 and `pend_rdata` is all zeros. The masks reset to all zeros. Reset `rst_n` is asynchronous and active low.
- R2: If bit i of the rise mask is 1 and `src_in[i]` goes from 0 to 1, pending bit i becomes 1 after the third rising clock edge that follows the change, and not earlier.
- R3: If bit i of the fall mask is 1 and `src_in[i]` goes from 1 to 0, pending bit i becomes 1 after the third rising clock edge that follows the change.
- R4: With both mask bits of a source set, the rising transition and the falling transition each set its pending bit.
- R5: A transition on a source whose two mask bits are both 0 leaves its pending bit at 0.
- R6: `irq` is 1 exactly when at least one pending bit is 1. It is 1 for as long as any bit remains pending.
- R7: A clear write (`clr_we` = 1) clears at that clock edge every pending bit whose `clr_wdata` bit is 1. It leaves the bits whose `clr_wdata` bit is 0 unchanged.
- R8: If an enabled edge and a clear of the same source meet at the same clock edge, the pending bit ends up set.
- R9: Writing 0 to the mask bits of a source does not clear a pending bit that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Asynchronous level status inputs |
| rise_we | input | 1 | Write strobe for the rise mask |
| rise_wdata | input | NUM_SRC | New rise-mask value |
| fall_we | input | 1 | Write strobe for the fall mask |
| fall_wdata | input | NUM_SRC | New fall-mask value |
| clr_we | input | 1 | Write strobe for the clear mask |
| clr_wdata | input | NUM_SRC | Pending bits to clear (1 = clear) |
| pend_rdata | output | NUM_SRC | Pending bits read back |
| irq | output | 1 | Active-high interrupt request |

## Verification
A source transition takes three rising edges to reach the pending bits: two synchroniser stages and one previous-value stage. The bench therefore checks a pending bit after two edges, to show it is still clear, and again after the third, to show it is set. Clear and mask writes act at the edge that samples the strobe. Their results are checked on the next falling edge, where `irq` follows the pending bits with no added delay. For the clear-versus-edge case, the clear strobe is placed on exactly the third edge after the source change, so that both land together.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] async_in,
  output logic [NUM_SRC-1:0] sync_out
);
  logic [NUM_SRC-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [NUM_SRC-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = async_in;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] level_in,
  input  logic [NUM_SRC-1:0] rise_mask,
  input  logic [NUM_SRC-1:0] fall_mask,
  output logic [NUM_SRC-1:0] event_out
);
  logic [NUM_SRC-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_in;
  end

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      edge_sel_e sel;
      logic      went_up;
      logic      went_down;
      always_comb begin
        sel       = edge_sel_e'({fall_mask[i], rise_mask[i]});
        went_up   = level_in[i] & ~prev_q[i];
        went_down = ~level_in[i] & prev_q[i];
        unique case (sel)
          EDGE_RISE: event_out[i] = went_up;
          EDGE_FALL: event_out[i] = went_down;
          EDGE_BOTH: event_out[i] = went_up | went_down;
          default:   event_out[i] = 1'b0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic               clr_en,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] pend_q
);
  logic [NUM_SRC-1:0] clr_eff;
  logic [NUM_SRC-1:0] pend_d;
  logic               upd_en;

  always_comb begin
    clr_eff = clr_en ? clr_vec : '0;
    upd_en  = clr_en | (|set_vec);
    // set takes priority over clear on the same edge
    pend_d  = (pend_q & ~clr_eff) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= '0;
    else if (upd_en) pend_q <= pend_d;
  end
endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               rise_we,
  input  logic [NUM_SRC-1:0] rise_wdata,
  input  logic               fall_we,
  input  logic [NUM_SRC-1:0] fall_wdata,
  input  logic               clr_we,
  input  logic [NUM_SRC-1:0] clr_wdata,
  output logic [NUM_SRC-1:0] pend_rdata,
  output logic               irq
);
  localparam int unsigned SYNC_N =
    (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic               rst_n_int;
  logic [NUM_SRC-1:0] rise_q, rise_d;
  logic [NUM_SRC-1:0] fall_q, fall_d;
  logic [NUM_SRC-1:0] src_sync;
  logic [NUM_SRC-1:0] evt;
  logic [NUM_SRC-1:0] pend_q;

  irq_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  always_comb begin
    rise_d = rise_wdata;
    fall_d = fall_wdata;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)   rise_q <= '0;
    else if (rise_we) rise_q <= rise_d;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)   fall_q <= '0;
    else if (fall_we) fall_q <= fall_d;
  end

  irq_sync_bank #(.NUM_SRC(NUM_SRC), .STAGES(SYNC_N)) i_sync (
    .clk(clk), .rst_n(rst_n_int), .async_in(src_in), .sync_out(src_sync)
  );

  irq_edge_det #(.NUM_SRC(NUM_SRC)) i_edge (
    .clk(clk), .rst_n(rst_n_int), .level_in(src_sync),
    .rise_mask(rise_q), .fall_mask(fall_q), .event_out(evt)
  );

  irq_pend_reg #(.NUM_SRC(NUM_SRC)) i_pend (
    .clk(clk), .rst_n(rst_n_int), .set_vec(evt),
    .clr_en(clr_we), .clr_vec(clr_wdata), .pend_q(pend_q)
  );

  assign pend_rdata = pend_q;
  assign irq        = |pend_q;
endmodule

// File: rtl/irq_edge_chk.sv
module irq_edge_chk #(
  parameter int unsigned NUM_SRC = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq,
  input logic [NUM_SRC-1:0] pend,
  input logic               clr_we,
  input logic [NUM_SRC-1:0] clr_wdata,
  input logic [NUM_SRC-1:0] en_any
);
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend) & ~pend & ~($past(clr_we) ? $past(clr_wdata) : '0)) == '0)); // R9

  AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(en_any)) == '0)); // R5

  AST_IRQ_FALL_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(clr_we)); // R7

  AST_IRQ_RISE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(en_any) != '0)); // R2
endmodule

bind irq_edge_ctrl irq_edge_chk #(.NUM_SRC(NUM_SRC)) i_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .pend(pend_rdata),
  .clr_we(clr_we), .clr_wdata(clr_wdata), .en_any(rise_q | fall_q)
);

// File: tb/test_irq_edge_ctrl.sv
`timescale 1ns/1ps
module test_irq_edge_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] src_in;
  logic         rise_we, fall_we, clr_we;
  logic [N-1:0] rise_wdata, fall_wdata, clr_wdata;
  logic [N-1:0] pend_rdata;
  logic         irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [N-1:0] exp_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_edge_ctrl #(.NUM_SRC(N), .SYNC_STAGES(2)) i_irq_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .rise_we(rise_we), .rise_wdata(rise_wdata),
    .fall_we(fall_we), .fall_wdata(fall_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .pend_rdata(pend_rdata), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(pend_rdata === exp_pend, req, pend_rdata, exp_pend);
    chk(irq === (exp_pend != '0), {req, " irq"}, {{(N-1){1'b0}}, irq},
        {{(N-1){1'b0}}, (exp_pend != '0)});
  endtask

  task automatic wr_masks(input logic [N-1:0] r, input logic [N-1:0] f);
    rise_we = 1'b1; rise_wdata = r;
    fall_we = 1'b1; fall_wdata = f;
    tick(1);
    rise_we = 1'b0; fall_we = 1'b0;
  endtask

  task automatic wr_clr(input logic [N-1:0] c);
    clr_we = 1'b1; clr_wdata = c;
    tick(1);
    clr_we = 1'b0; clr_wdata = '0;
    exp_pend = exp_pend & ~c;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    tick(3);
    exp_pend = '0;
    chk_state("R1 during reset");
    rst_n = 1'b1;
    tick(4);
    chk_state("R1 after reset");
  endtask

  task automatic t_rise;
    wr_masks(16'h0001, 16'h0000);
    src_in[0] = 1'b1;
    tick(2);
    chk_state("R2 not before third edge");
    tick(1);
    exp_pend[0] = 1'b1;
    chk_state("R2 rise sets pending");
    src_in[0] = 1'b0;
    tick(4);
    chk_state("R2 fall ignored with rise-only mask");
    wr_clr(16'h0001);
    chk_state("R7 clear bit0");
  endtask

  task automatic t_fall;
    wr_masks(16'h0000, 16'h0008);
    src_in[3] = 1'b1;
    tick(4);
    chk_state("R3 rise ignored with fall-only mask");
    src_in[3] = 1'b0;
    tick(2);
    chk_state("R3 not before third edge");
    tick(1);
    exp_pend[3] = 1'b1;
    chk_state("R3 fall sets pending");
    wr_clr(16'h0008);
  endtask

  task automatic t_both;
    wr_masks(16'h0020, 16'h0020);
    src_in[5] = 1'b1;
    tick(3);
    exp_pend[5] = 1'b1;
    chk_state("R4 rise with both enables");
    wr_clr(16'h0020);
    chk_state("R4 cleared");
    src_in[5] = 1'b0;
    tick(3);
    exp_pend[5] = 1'b1;
    chk_state("R4 fall with both enables");
    wr_clr(16'h0020);
  endtask

  task automatic t_none;
    wr_masks(16'h0000, 16'h0000);
    src_in[7] = 1'b1;
    tick(4);
    src_in[7] = 1'b0;
    tick(4);
    chk_state("R5 no enable no pending");
  endtask

  task automatic t_select_clear;
    wr_masks(16'h0009, 16'h0000);
    src_in[0] = 1'b1; src_in[3] = 1'b1;
    tick(3);
    exp_pend[0] = 1'b1; exp_pend[3] = 1'b1;
    chk_state("R6 two pending");
    wr_clr(16'h0001);
    chk_state("R7 only bit0 cleared, R6 irq stays high");
    wr_clr(16'h0008);
    chk_state("R6 irq low when none pending");
    src_in[0] = 1'b0; src_in[3] = 1'b0;
    tick(4);
  endtask

  task automatic t_race;
    wr_masks(16'h0004, 16'h0004);
    src_in[2] = 1'b1;
    tick(3);
    exp_pend[2] = 1'b1;
    chk_state("R8 setup pending");
    src_in[2] = 1'b0;
    tick(2);
    clr_we = 1'b1; clr_wdata = 16'h0004;
    tick(1);
    clr_we = 1'b0; clr_wdata = '0;
    chk_state("R8 edge wins over clear");
    wr_clr(16'h0004);
    chk_state("R8 later clear works");
  endtask

  task automatic t_disable;
    wr_masks(16'h0400, 16'h0000);
    src_in[10] = 1'b1;
    tick(3);
    exp_pend[10] = 1'b1;
    wr_masks(16'h0000, 16'h0000);
    tick(2);
    chk_state("R9 disable keeps pending");
    wr_clr(16'h0400);
    chk_state("R9 cleared afterwards");
  endtask

  initial begin
    src_in = '0; rise_we = 0; fall_we = 0; clr_we = 0;
    rise_wdata = '0; fall_wdata = '0; clr_wdata = '0;
    exp_pend = '0;
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_none();
    t_select_clear();
    t_race();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule